// File: doc/BRIEF.md
# System Interrupt Enable and Flag Registers

This block sits at the bottom of a peripheral address space. It holds one byte of interrupt enables and one byte of interrupt flags for system-level events: watchdog expiry, a watchdog password fault, an oscillator failure, the non-maskable pin, a flash access violation, a brownout and a reset from the external pin. The sources of these events are outside the block. The watchdog, the clock monitor, the flash controller and the reset sequencer each report to it through single-cycle strobes or level inputs. Software reads and writes the two bytes through a simple byte bus and is told about pending work through one interrupt request line.

Three reset levels are nested. Brownout is the deepest, power-on is in the middle and the clear level is the shallowest. Each level is an active-high synchronous input. A deeper level always implies the shallower ones, and the block derives that itself, so the reset sequencer may assert a single line. Each register bit is tied to one level, which decides when it returns to its reset value. Some flags therefore survive a shallow reset and tell software what caused it.

The bus is a plain register port, not a stream. A write takes effect at the clock edge where `bus_sel_i` and `bus_we_i` are both high. Read data is combinational from the selected address while `bus_sel_i` is high. The port never stalls, so there is no back-pressure and no ready signal.

Top module: `sys_irq_regs`

## Requirements
- R1: The enable byte is at byte address 0x00 with bit 0 watchdog, bit 1 oscillator, bit 2 NMI pin and bit 3 flash violation. The flag byte is at byte address 0x02 with bit 0 watchdog, bit 1 oscillator, bit 2 brownout, bit 3 pin reset and bit 4 NMI pin. Every other address reads 0x00 and ignores writes.
- R2: Bits that have no function read as zero, and writes to them are ignored.
- R3: Every enable bit clears to 0 on any reset level (clear, power-on or brownout).
- R4: The watchdog flag sets on a watchdog overflow or on a watchdog key error. It clears on power-on or brownout reset and keeps its value across a clear-level reset alone.
- R5: A brownout reset sets the brownout flag to 1. Power-on and clear-level resets leave the flag unchanged, and software may clear it.
- R6: The pin-reset flag sets on a pin reset event. Only a brownout reset clears it; it survives power-on and clear-level resets.
- R7: The oscillator flag sets while a fault is reported and clears on a clear-level reset. A software clear takes effect only while no fault is present.
- R8: The NMI flag sets on an NMI pin event only while the pin is configured for NMI (`nmi_sel_i` = 1). It clears on a clear-level reset.
- R9: A flag byte write clears each flag whose data bit is 0. Data bits of 1 leave the flags unchanged, so software can never set a flag.
- R10: When a hardware set event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R11: `irq_o` is high whenever the oscillator flag, the NMI flag or the external flash violation input is high together with its enable bit.
- R12: The watchdog enable contributes to `irq_o` only while `wdog_interval_i` is 1. In watchdog reset mode a set watchdog flag never raises `irq_o`.
- R13: A reset level that governs a bit takes priority over a set event in the same cycle. The bit takes its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_brown_i | input | 1 | Brownout reset level, synchronous, active high |
| rst_pwr_i | input | 1 | Power-on reset level, synchronous, active high |
| rst_clr_i | input | 1 | Clear-level reset, synchronous, active high |
| bus_sel_i | input | 1 | Bus access select |
| bus_we_i | input | 1 | Write strobe, qualified by select |
| bus_addr_i | input | AW | Byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, zero when not selected |
| wdog_ovf_i | input | 1 | Watchdog counter overflow strobe |
| wdog_key_err_i | input | 1 | Watchdog key violation strobe |
| wdog_interval_i | input | 1 | 1 while the watchdog runs as an interval timer |
| osc_fault_i | input | 1 | Oscillator fault level |
| pin_rst_evt_i | input | 1 | Reset pin caused a reset (strobe) |
| nmi_edge_i | input | 1 | NMI pin event strobe |
| nmi_sel_i | input | 1 | Reset pin is configured as NMI |
| flash_viol_i | input | 1 | Flash access violation flag from the flash controller |
| irq_o | output | 1 | Interrupt request |

## Verification
The bound checker watches every cycle for the following:
- enables at zero after any reset level;
- the brownout, pin-reset and watchdog flags in the right state after a brownout;
- the watchdog flag surviving a clear-level reset;
- the oscillator flag holding while a fault persists;
- a pin reset event winning over a same-cycle clear;
- the padding bits of read data staying zero;
- no request in watchdog reset mode while the other enables are off.

Only the bench scenarios can show the following:
- the address map and the bit layout;
- the write-zero-to-clear rule and the rule that writing one has no effect;
- the NMI configuration gate;
- the full retain-or-clear pattern of every flag across each of the three reset levels in turn.

// File: rtl/sys_irq_pkg.sv
package sys_irq_pkg;

  localparam int unsigned DW = 8;

  // reset levels, shallow to deep
  typedef enum logic [1:0] {
    LVL_CLEAR = 2'd0,
    LVL_POWER = 2'd1,
    LVL_BROWN = 2'd2
  } rst_lvl_e;
  localparam int unsigned LVL_NUM = 3;

  // enable byte layout
  localparam int unsigned IE_WDOG  = 0;
  localparam int unsigned IE_OSC   = 1;
  localparam int unsigned IE_NMI   = 2;
  localparam int unsigned IE_FLASH = 3;
  localparam int unsigned IE_NUM   = 4;

  // flag byte layout
  localparam int unsigned FL_WDOG  = 0;
  localparam int unsigned FL_OSC   = 1;
  localparam int unsigned FL_BROWN = 2;
  localparam int unsigned FL_PIN   = 3;
  localparam int unsigned FL_NMI   = 4;
  localparam int unsigned FL_NUM   = 5;

  function automatic rst_lvl_e flag_level(input int unsigned idx);
    case (idx)
      FL_WDOG:  return LVL_POWER;
      FL_BROWN: return LVL_BROWN;
      FL_PIN:   return LVL_BROWN;
      default:  return LVL_CLEAR;
    endcase
  endfunction

  function automatic logic flag_rst_value(input int unsigned idx);
    return (idx == FL_BROWN);
  endfunction

endpackage

// File: rtl/sys_irq_level_decode.sv
// Expands the three reset inputs into nested per-level hits.
module sys_irq_level_decode
  import sys_irq_pkg::*;
(
  input  logic               rst_brown_i,
  input  logic               rst_pwr_i,
  input  logic               rst_clr_i,
  output logic [LVL_NUM-1:0] lvl_hit_o
);
  always_comb begin
    lvl_hit_o            = '0;
    lvl_hit_o[LVL_BROWN] = rst_brown_i;
    lvl_hit_o[LVL_POWER] = rst_brown_i | rst_pwr_i;
    lvl_hit_o[LVL_CLEAR] = rst_brown_i | rst_pwr_i | rst_clr_i;
  end
endmodule

// File: rtl/sys_irq_flag_cell.sv
// One flag bit: own reset level first, then hardware set, then software clear.
module sys_irq_flag_cell
  import sys_irq_pkg::*;
#(
  parameter rst_lvl_e LEVEL   = LVL_CLEAR,
  parameter logic     RST_VAL = 1'b0
) (
  input  logic               clk_i,
  input  logic [LVL_NUM-1:0] lvl_hit_i,
  input  logic               set_i,
  input  logic               clr_i,
  output logic               q_o
);
  localparam int unsigned LIDX = int'(LEVEL);

  always_ff @(posedge clk_i) begin
    if (lvl_hit_i[LIDX])
      q_o <= RST_VAL;
    else if (set_i)
      q_o <= 1'b1;
    else if (clr_i)
      q_o <= 1'b0;
  end
endmodule

// File: rtl/sys_irq_enable_reg.sv
// Enable bits, fully software written, cleared by the shallowest reset level.
module sys_irq_enable_reg #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)
      q_o <= '0;
    else if (we_i)
      q_o <= wdata_i;
  end
endmodule

// File: rtl/sys_irq_req_logic.sv
// Combines flags with enables into a single request.
module sys_irq_req_logic
  import sys_irq_pkg::*;
(
  input  logic [IE_NUM-1:0] ie_i,
  input  logic [FL_NUM-1:0] flg_i,
  input  logic              flash_viol_i,
  input  logic              wdog_interval_i,
  output logic              irq_o
);
  logic [IE_NUM-1:0] src;

  always_comb begin
    src           = '0;
    src[IE_WDOG]  = flg_i[FL_WDOG] & wdog_interval_i;
    src[IE_OSC]   = flg_i[FL_OSC];
    src[IE_NMI]   = flg_i[FL_NMI];
    src[IE_FLASH] = flash_viol_i;
    irq_o         = |(src & ie_i);
  end
endmodule

// File: rtl/sys_irq_regs.sv
module sys_irq_regs
  import sys_irq_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter int unsigned ADDR_IE  = 0,
  parameter int unsigned ADDR_FLG = 2
) (
  input  logic          clk_i,
  input  logic          rst_brown_i,
  input  logic          rst_pwr_i,
  input  logic          rst_clr_i,
  input  logic          bus_sel_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          wdog_ovf_i,
  input  logic          wdog_key_err_i,
  input  logic          wdog_interval_i,
  input  logic          osc_fault_i,
  input  logic          pin_rst_evt_i,
  input  logic          nmi_edge_i,
  input  logic          nmi_sel_i,
  input  logic          flash_viol_i,
  output logic          irq_o
);
  localparam logic [AW-1:0] IE_A  = AW'(ADDR_IE);
  localparam logic [AW-1:0] FLG_A = AW'(ADDR_FLG);

  logic [LVL_NUM-1:0] lvl_hit;
  logic               hit_ie, hit_flg;
  logic [IE_NUM-1:0]  ie_q;
  logic [FL_NUM-1:0]  flg_q;
  logic [FL_NUM-1:0]  flg_set;
  logic [FL_NUM-1:0]  flg_clr;
  logic               unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DW-1:FL_NUM];

  sys_irq_level_decode u_lvl (
    .rst_brown_i (rst_brown_i),
    .rst_pwr_i   (rst_pwr_i),
    .rst_clr_i   (rst_clr_i),
    .lvl_hit_o   (lvl_hit)
  );

  assign hit_ie  = bus_sel_i && (bus_addr_i == IE_A);
  assign hit_flg = bus_sel_i && (bus_addr_i == FLG_A);

  sys_irq_enable_reg #(.N(IE_NUM)) u_ie (
    .clk_i   (clk_i),
    .rst_i   (lvl_hit[LVL_CLEAR]),
    .we_i    (hit_ie && bus_we_i),
    .wdata_i (bus_wdata_i[IE_NUM-1:0]),
    .q_o     (ie_q)
  );

  // hardware set sources per flag
  always_comb begin
    flg_set           = '0;
    flg_set[FL_WDOG]  = wdog_ovf_i | wdog_key_err_i;
    flg_set[FL_OSC]   = osc_fault_i;
    flg_set[FL_BROWN] = 1'b0;
    flg_set[FL_PIN]   = pin_rst_evt_i;
    flg_set[FL_NMI]   = nmi_edge_i & nmi_sel_i;
  end

  // software clears where a zero is written
  assign flg_clr = (hit_flg && bus_we_i) ? ~bus_wdata_i[FL_NUM-1:0] : '0;

  for (genvar gi = 0; gi < FL_NUM; gi++) begin : g_flag
    sys_irq_flag_cell #(
      .LEVEL   (flag_level(gi)),
      .RST_VAL (flag_rst_value(gi))
    ) u_cell (
      .clk_i     (clk_i),
      .lvl_hit_i (lvl_hit),
      .set_i     (flg_set[gi]),
      .clr_i     (flg_clr[gi]),
      .q_o       (flg_q[gi])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (hit_ie)
      bus_rdata_o = {{(DW-IE_NUM){1'b0}}, ie_q};
    else if (hit_flg)
      bus_rdata_o = {{(DW-FL_NUM){1'b0}}, flg_q};
  end

  sys_irq_req_logic u_req (
    .ie_i            (ie_q),
    .flg_i           (flg_q),
    .flash_viol_i    (flash_viol_i),
    .wdog_interval_i (wdog_interval_i),
    .irq_o           (irq_o)
  );

endmodule

// File: rtl/sys_irq_regs_chk.sv
module sys_irq_regs_chk
  import sys_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_brown_i,
  input logic              rst_pwr_i,
  input logic              rst_clr_i,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic [DW-1:0]     bus_rdata_o,
  input logic              wdog_interval_i,
  input logic              osc_fault_i,
  input logic              pin_rst_evt_i,
  input logic              irq_o,
  input logic [IE_NUM-1:0] ie_q,
  input logic [FL_NUM-1:0] flg_q
);

  // R3
  ie_reset_chk: assert property (@(posedge clk_i) disable iff (rst_brown_i)
    $past(rst_clr_i | rst_pwr_i | rst_brown_i) |-> (ie_q == '0));

  // R5
  brown_after_chk: assert property (@(posedge clk_i) disable iff (rst_brown_i)
    $past(rst_brown_i) |-> (flg_q[FL_BROWN] && !flg_q[FL_PIN] && !flg_q[FL_WDOG]));

  // R4
  wdog_keep_chk: assert property (@(posedge clk_i) disable iff (rst_brown_i)
    (rst_clr_i && !rst_pwr_i && flg_q[FL_WDOG] && !(bus_sel_i && bus_we_i))
      |=> flg_q[FL_WDOG]);

  // R7
  osc_hold_chk: assert property (@(posedge clk_i) disable iff (rst_brown_i)
    (osc_fault_i && !rst_clr_i && !rst_pwr_i) |=> flg_q[FL_OSC]);

  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (rst_brown_i)
    pin_rst_evt_i |=> flg_q[FL_PIN]);

  // R2
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (rst_brown_i)
    bus_sel_i |-> (bus_rdata_o[DW-1:FL_NUM] == '0));

  // R12
  wdog_gate_chk: assert property (@(posedge clk_i) disable iff (rst_brown_i)
    (!wdog_interval_i && (ie_q[IE_FLASH:IE_OSC] == '0)) |-> !irq_o);

endmodule

bind sys_irq_regs sys_irq_regs_chk u_chk (
  .clk_i           (clk_i),
  .rst_brown_i     (rst_brown_i),
  .rst_pwr_i       (rst_pwr_i),
  .rst_clr_i       (rst_clr_i),
  .bus_sel_i       (bus_sel_i),
  .bus_we_i        (bus_we_i),
  .bus_rdata_o     (bus_rdata_o),
  .wdog_interval_i (wdog_interval_i),
  .osc_fault_i     (osc_fault_i),
  .pin_rst_evt_i   (pin_rst_evt_i),
  .irq_o           (irq_o),
  .ie_q            (ie_q),
  .flg_q           (flg_q)
);

// File: tb/sys_irq_regs_tb_top.sv
module sys_irq_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  typedef struct {
    logic [7:0] data;
    logic       irq;
    string      tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_brown = 1'b1, rst_pwr = 1'b1, rst_clr = 1'b1;
  logic          sel = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          wovf = 0, wkey = 0, wint = 0, osc = 0, pin = 0, nmi = 0, nmisel = 0, flash = 0;
  logic          irq;

  int   n_run = 0, n_fail = 0;
  bit   done = 0;
  exp_t sb_q[$];
  event rd_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_irq_regs #(.AW(AW)) dut_i (
    .clk_i(clk), .rst_brown_i(rst_brown), .rst_pwr_i(rst_pwr), .rst_clr_i(rst_clr),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .wdog_ovf_i(wovf), .wdog_key_err_i(wkey),
    .wdog_interval_i(wint), .osc_fault_i(osc), .pin_rst_evt_i(pin),
    .nmi_edge_i(nmi), .nmi_sel_i(nmisel), .flash_viol_i(flash), .irq_o(irq)
  );

  // monitor: pops the expected item and compares it with the live outputs
  always begin
    @(rd_ev);
    #1;
    if (sb_q.size() != 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_run++;
      if (rdata !== e.data || irq !== e.irq) begin
        n_fail++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                 e.tag, rdata, irq, e.data, e.irq);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    sel = 1; we = 1; addr = a; wdata = d;
    step();
    sel = 0; we = 0;
  endtask

  // driver: pushes the expected item, then performs the read
  task automatic rd(input logic [AW-1:0] a, input logic [7:0] d, input logic i, input string tag);
    exp_t e;
    e.data = d; e.irq = i; e.tag = tag;
    sb_q.push_back(e);
    sel = 1; we = 0; addr = a;
    -> rd_ev;
    #2;
    sel = 0;
  endtask

  initial begin
    #(CLK_PERIOD*10000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(); step();
    rst_brown = 0; rst_pwr = 0; rst_clr = 0;
    // reset state
    rd(8'h00, 8'h00, 0, "R3 enables after reset");
    rd(8'h02, 8'h04, 0, "R5 brownout flag after reset");
    // map and unimplemented bits
    wr(8'h00, 8'hFF);
    rd(8'h00, 8'h0F, 0, "R1 R2 enable byte readback");
    wr(8'h01, 8'hFF);
    rd(8'h01, 8'h00, 0, "R1 unmapped address");
    rd(8'h02, 8'h04, 0, "R1 flag byte untouched");
    // software clear rules
    wr(8'h02, 8'hFB);
    rd(8'h02, 8'h00, 0, "R5 R9 brownout cleared by zero");
    wr(8'h02, 8'hFF);
    rd(8'h02, 8'h00, 0, "R9 ones do not set");
    // oscillator
    osc = 1; step();
    rd(8'h02, 8'h02, 1, "R7 R11 oscillator flag");
    wr(8'h02, 8'h00);
    rd(8'h02, 8'h02, 1, "R7 clear blocked during fault");
    osc = 0;
    wr(8'h02, 8'h00);
    rd(8'h02, 8'h00, 0, "R7 clear after fault gone");
    // NMI pin gate
    nmi = 1; step(); nmi = 0;
    rd(8'h02, 8'h00, 0, "R8 event ignored in reset config");
    nmisel = 1; nmi = 1; step(); nmi = 0;
    rd(8'h02, 8'h10, 1, "R8 R11 NMI flag");
    wr(8'h02, 8'h00);
    rd(8'h02, 8'h00, 0, "R9 NMI cleared");
    // flash violation input
    flash = 1;
    rd(8'h02, 8'h00, 1, "R11 flash violation request");
    wr(8'h00, 8'h07);
    rd(8'h00, 8'h07, 0, "R11 flash request masked");
    flash = 0;
    // watchdog
    wint = 0; wovf = 1; step(); wovf = 0;
    rd(8'h02, 8'h01, 0, "R12 watchdog mode no request");
    wint = 1;
    rd(8'h02, 8'h01, 1, "R12 interval mode request");
    wr(8'h02, 8'h00);
    rd(8'h02, 8'h00, 0, "R9 watchdog cleared");
    wkey = 1; step(); wkey = 0;
    rd(8'h02, 8'h01, 1, "R4 key error sets watchdog flag");
    wint = 0;
    wr(8'h02, 8'h00);
    // set beats clear
    pin = 1; wr(8'h02, 8'h00); pin = 0;
    rd(8'h02, 8'h08, 0, "R10 R6 set wins over clear");
    // clear-level reset
    wr(8'h00, 8'h0F);
    osc = 1; step(); osc = 0;
    nmi = 1; step(); nmi = 0;
    wovf = 1; step(); wovf = 0;
    rd(8'h02, 8'h1B, 1, "R4 R7 R8 flags before clear reset");
    rst_clr = 1; step(); rst_clr = 0;
    rd(8'h00, 8'h00, 0, "R3 enables cleared by clear level");
    rd(8'h02, 8'h09, 0, "R4 R6 R7 R8 flags after clear level");
    // power-on reset
    rst_pwr = 1; step(); rst_pwr = 0;
    rd(8'h02, 8'h08, 0, "R4 R6 flags after power-on");
    // brownout with same-cycle pin event
    rst_brown = 1; pin = 1; step(); rst_brown = 0; pin = 0;
    rd(8'h02, 8'h04, 0, "R13 R5 R6 flags after brownout");
    rd(8'h03, 8'h00, 0, "R1 address 0x03 reads zero");
    rd(8'hFF, 8'h00, 0, "R1 address 0xFF reads zero");
    #3;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule